// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers a set of interrupt inputs (32 by default) and presents a single active-low request line to a processor. Each input has its own settings: a 3-bit priority, a choice of edge or level sensitivity, an enable bit and a full-width vector word. When the request is seen, software reads a side-effecting "take" register. That read returns the vector of the best pending source and makes the source's priority the current level. The previous level goes onto an internal hardware stack, and the request line drops.

Only a source whose priority is strictly above the current level can raise the request again, so interrupts nest by priority. A write to the "done" register ends the current service. It pops the stack and restores the level that was interrupted. If something pending is above that restored level, the request comes back, even when that source does not outrank the level that just ended. Inputs are synchronized to the block clock. Edge-mode sources latch a pending bit on a rising edge, and a take clears that bit. Level-mode sources are pending for exactly as long as their synchronized input is high.

The register bus is a plain one: single-cycle read or write strobes with an 8-bit address. Read data appears registered one cycle after the read strobe.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset, `irq_n` is 1, the level register (address 0x83) reads 0 and the pending register (address 0x82) reads 0.
- R2: A read of address 0x80 returns the vector word (written at 0x40+n) of the enabled pending source with the greatest priority. When priorities are equal, the lowest source number wins.
- R3: A successful take makes the current level active with the taken source's priority. The level register reads bit 3 = 1 and bits 2:0 = priority. `irq_n` returns to 1 unless a source strictly above that priority is pending.
- R4: In edge mode (bit 4 of the per-source word at address n), a rising input edge latches a pending bit, and taking that source clears it.
- R5: In level mode (bit 4 = 0), the pending bit equals the synchronized input. A take does not clear it.
- R6: A source whose enable bit (bit 5) is 0 never drives `irq_n` low, yet an edge seen while it is disabled still sets its pending bit. Enabling it later raises the request.
- R7: `irq_n` is 0 exactly when an enabled pending source has priority strictly above the current level. With no active level, every priority qualifies, including 0.
- R8: Each take pushes the previous level onto the stack. A write to address 0x81 pops it and restores that level (inactive if it was the outermost). A write to 0x81 with an empty stack changes nothing.
- R9: After a pop, the request is asserted again if any enabled pending source is above the restored level, even if that source is at or below the level that just ended.
- R10: Eight takes at levels 0 through 7 nest fully and unwind through eight pops, with every intermediate level restored in order.
- R11: A read of 0x80 while `irq_n` is 1 returns 0 and changes neither the level nor any pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_in | input | NUM_SRC | Raw interrupt inputs, asynchronous |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after `bus_rd` |
| irq_n | output | 1 | Active-low interrupt request to the processor |

## Verification
The arbitration is swept over every non-empty combination of eight level-mode inputs. The priorities repeat across sources, so the sweep separates a correct tie-break from a priority-only choice. Each combination also confirms that a take drops the request and that a pop returns to the idle level. Directed edge pulses show how the edge and level modes differ in clearing. A pulse on a disabled source shows that latching and requesting are separate. Three interleaved nesting sequences test the pop-and-reassert rule: one higher arrival, one equal arrival and one lower arrival. A staircase through all eight levels fills the stack and drains it again.

// File: rtl/nic_pkg.sv
// Shared constants and types for the nested priority interrupt controller.
// Assumes an 8-bit register address and 3-bit priorities.
package nic_pkg;
    localparam int PRIO_W     = 3;
    localparam int NUM_LEVELS = 1 << PRIO_W;
    localparam int ADDR_W     = 8;

    localparam logic [ADDR_W-1:0] A_TAKE  = 8'h80;
    localparam logic [ADDR_W-1:0] A_DONE  = 8'h81;
    localparam logic [ADDR_W-1:0] A_PEND  = 8'h82;
    localparam logic [ADDR_W-1:0] A_LEVEL = 8'h83;

    localparam int CFG_EDGE_BIT = 4;
    localparam int CFG_EN_BIT   = 5;

    typedef logic [PRIO_W-1:0] prio_t;

    typedef struct packed {
        logic  active;
        prio_t prio;
    } level_t;
endpackage

// File: rtl/nic_src_cell.sv
// One interrupt input: two-flop synchronizer, rising-edge detector and
// pending flag. Level mode reports the synchronized input directly; edge
// mode latches a pending bit that only a take clears. Assumes the raw
// input is held at least two clocks for an edge to be seen.
module nic_src_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    input  logic edge_mode,
    input  logic clr,
    output logic pend
);
    logic s1_q, s2_q, prev_q, pend_q;
    logic rise;

    assign rise = s2_q & ~prev_q;

    // Synchronize the raw input and keep last cycle's value for edge detect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q   <= 1'b0;
            s2_q   <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            s1_q   <= raw_in;
            s2_q   <= s1_q;
            prev_q <= s2_q;
        end
    end

    // Edge-mode pending latch: set on a rise, cleared by a take.
    always_ff @(posedge clk) begin
        if (!rst_n || !edge_mode) begin
            pend_q <= 1'b0;
        end else if (rise) begin
            pend_q <= 1'b1;
        end else if (clr) begin
            pend_q <= 1'b0;
        end
    end

    assign pend = edge_mode ? pend_q : s2_q;

    p_edge_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && clr && !rise) |=> !pend_q);

    p_edge_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && rise) |=> pend_q);
endmodule

// File: rtl/nic_arbiter.sv
// Combinational winner search over all sources: picks the enabled
// pending source with the greatest priority. When priorities tie, the
// lowest index wins. Assumes NUM_SRC >= 2.
module nic_arbiter
    import nic_pkg::*;
#(
    parameter int NUM_SRC = 32,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] pend,
    input  logic [NUM_SRC-1:0] en,
    input  prio_t              prio [NUM_SRC],
    output logic               win_valid,
    output logic [IDX_W-1:0]   win_idx,
    output prio_t              win_prio
);
    // Scan from the top index down so that on a tie the lower index overrides.
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        win_prio  = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend[i] && en[i] && (!win_valid || prio[i] >= win_prio)) begin
                win_valid = 1'b1;
                win_idx   = IDX_W'(i);
                win_prio  = prio[i];
            end
        end
    end
endmodule

// File: rtl/nic_level_stack.sv
// Hardware stack of saved priority levels. Push stores the interrupted
// level; pop exposes the entry below. Assumes the owner never pushes when
// full and never pops when empty.
module nic_level_stack
    import nic_pkg::*;
#(
    parameter int DEPTH  = NUM_LEVELS,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   push,
    input  level_t push_lvl,
    input  logic   pop,
    output level_t top_lvl,
    output logic   empty,
    output logic   full
);
    level_t           mem [DEPTH];
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_m1;

    assign empty  = (cnt_q == '0);
    assign full   = (cnt_q == CNT_W'(DEPTH));
    assign cnt_m1 = cnt_q - CNT_W'(1);

    // Occupancy counter: grows on push, shrinks on pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (push && !full) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end else if (pop && !empty) begin
            cnt_q <= cnt_m1;
        end
    end

    // Entry storage: writes the pushed level at the current fill point.
    always_ff @(posedge clk) begin
        if (push && !full) begin
            mem[cnt_q[PTR_W-1:0]] <= push_lvl;
        end
    end

    assign top_lvl = empty ? '0 : mem[cnt_m1[PTR_W-1:0]];

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/nest_irq_ctrl.sv
// Nested priority interrupt controller top. Holds per-source settings and
// vectors, the current priority level and the register decode. A take
// read returns the winning vector and pushes the level; a done write pops
// it. Assumes 2 <= NUM_SRC <= 32 and DATA_W >= max(NUM_SRC, 6).
// Register map: 0x00+n settings {en[5], edge[4], prio[2:0]}, 0x40+n vector,
// 0x80 take (read), 0x81 done (write), 0x82 pending (read), 0x83 level (read).
module nest_irq_ctrl
    import nic_pkg::*;
#(
    parameter int NUM_SRC     = 32,
    parameter int DATA_W      = 32,
    parameter int STACK_DEPTH = NUM_LEVELS,
    localparam int IDX_W      = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic               bus_rd,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq_n
);
    prio_t              cfg_prio [NUM_SRC];
    logic [NUM_SRC-1:0] cfg_edge;
    logic [NUM_SRC-1:0] cfg_en;
    logic [DATA_W-1:0]  vec_q    [NUM_SRC];
    level_t             cur_q;

    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] clr;
    logic               win_valid;
    logic [IDX_W-1:0]   win_idx;
    prio_t              win_prio;
    level_t             stk_top;
    logic               stk_empty;
    logic               stk_full;

    logic [IDX_W-1:0]   sel_idx;
    logic               idx_ok;
    logic               cfg_wr, vec_wr, take_rd, take_fire, done_wr, req;
    logic [DATA_W-1:0]  rd_next;

    // Address decode for the per-source windows and the control registers.
    assign sel_idx   = bus_addr[IDX_W-1:0];
    assign idx_ok    = ({2'b00, bus_addr[5:0]} < ADDR_W'(NUM_SRC));
    assign cfg_wr    = bus_wr && (bus_addr[7:6] == 2'b00) && idx_ok;
    assign vec_wr    = bus_wr && (bus_addr[7:6] == 2'b01) && idx_ok;
    assign take_rd   = bus_rd && (bus_addr == A_TAKE);
    assign req       = win_valid && (!cur_q.active || (win_prio > cur_q.prio));
    assign take_fire = take_rd && req;
    assign done_wr   = bus_wr && (bus_addr == A_DONE) && !stk_empty;
    assign irq_n     = ~req;

    // One sampling cell per source, each cleared only when it is taken.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign clr[g] = take_fire && (win_idx == IDX_W'(g));
        nic_src_cell u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .raw_in    (src_in[g]),
            .edge_mode (cfg_edge[g]),
            .clr       (clr[g]),
            .pend      (pend[g])
        );
    end

    nic_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
        .pend      (pend),
        .en        (cfg_en),
        .prio      (cfg_prio),
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .win_prio  (win_prio)
    );

    nic_level_stack #(.DEPTH(STACK_DEPTH)) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (take_fire),
        .push_lvl (cur_q),
        .pop      (done_wr),
        .top_lvl  (stk_top),
        .empty    (stk_empty),
        .full     (stk_full)
    );

    // Per-source settings and vectors written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_edge <= '0;
            cfg_en   <= '0;
            for (int i = 0; i < NUM_SRC; i++) begin
                cfg_prio[i] <= '0;
                vec_q[i]    <= '0;
            end
        end else begin
            if (cfg_wr) begin
                cfg_prio[sel_idx] <= bus_wdata[PRIO_W-1:0];
                cfg_edge[sel_idx] <= bus_wdata[CFG_EDGE_BIT];
                cfg_en[sel_idx]   <= bus_wdata[CFG_EN_BIT];
            end
            if (vec_wr) begin
                vec_q[sel_idx] <= bus_wdata;
            end
        end
    end

    // Current level: raised by a take, restored from the stack by done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else if (take_fire) begin
            cur_q <= '{active: 1'b1, prio: win_prio};
        end else if (done_wr) begin
            cur_q <= stk_top;
        end
    end

    // Read data selection for the addressed register.
    always_comb begin
        rd_next = '0;
        if (take_rd) begin
            rd_next = req ? vec_q[win_idx] : '0;
        end else if (bus_addr == A_PEND) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                rd_next[i] = pend[i];
            end
        end else if (bus_addr == A_LEVEL) begin
            rd_next[PRIO_W:0] = cur_q;
        end else if ((bus_addr[7:6] == 2'b00) && idx_ok) begin
            rd_next[PRIO_W-1:0]  = cfg_prio[sel_idx];
            rd_next[CFG_EDGE_BIT] = cfg_edge[sel_idx];
            rd_next[CFG_EN_BIT]   = cfg_en[sel_idx];
        end else if ((bus_addr[7:6] == 2'b01) && idx_ok) begin
            rd_next = vec_q[sel_idx];
        end
    end

    // Registered read data, updated only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_next;
        end
    end

    p_winner_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (cfg_en[win_idx] && pend[win_idx]));

    p_take_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take_fire |=> (cur_q.active && (cur_q.prio == $past(win_prio))));

    p_pop_restore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_wr |=> (cur_q == $past(stk_top)));

    p_no_push_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
        take_fire |-> !stk_full);

    p_idle_take_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (take_rd && !req) |=> $stable(cur_q));
endmodule

// File: tb/tb_nest_irq_ctrl.sv
module tb_nest_irq_ctrl;
    import nic_pkg::*;

    localparam int NS = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src = '0;
    logic          bus_rd = 1'b0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          irq_n;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    nest_irq_ctrl #(.NUM_SRC(NS), .DATA_W(32)) dut (
        .clk(clk), .rst_n(rst_n), .src_in(src),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_n(irq_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int sweep_prio(int i);
        return (i * 3) % 5;
    endfunction

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic set_src(input int i, input int p, input bit edge_m, input bit en);
        bus_write(8'(i), {26'b0, en, edge_m, 1'b0, 3'(p)});
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse(input int k);
        @(negedge clk);
        src[k] = 1'b1;
        repeat (2) @(negedge clk);
        src[k] = 1'b0;
        settle();
    endtask

    task automatic expect_level(input string tag, input bit act_on, input int p);
        logic [31:0] d;
        bus_read(A_LEVEL, d);
        chk(tag, d, act_on ? (32'h8 | 32'(p)) : 32'h0);
    endtask

    task automatic take(input string tag, input int idx);
        logic [31:0] d;
        bus_read(A_TAKE, d);
        chk(tag, d, 32'hA000 + 32'(idx));
    endtask

    task automatic done();
        bus_write(A_DONE, 32'h0);
    endtask

    initial begin : main
        logic [31:0] d;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 irq_n", 32'(irq_n), 32'h1);
        bus_read(A_LEVEL, d); chk("R1 level", d, 32'h0);
        bus_read(A_PEND, d);  chk("R1 pend", d, 32'h0);

        for (int i = 0; i < NS; i++) begin
            bus_write(8'h40 + 8'(i), 32'hA000 + 32'(i));
        end

        // R2/R3/R7: sweep all input patterns in level mode with tied priorities
        for (int i = 0; i < NS; i++) set_src(i, sweep_prio(i), 1'b0, 1'b1);
        for (int m = 1; m < (1 << NS); m++) begin
            int best;
            best = -1;
            for (int i = 0; i < NS; i++) begin
                if (m[i] && (best < 0 || sweep_prio(i) > sweep_prio(best))) best = i;
            end
            @(negedge clk);
            src = NS'(m);
            settle();
            chk("R7 request raised", 32'(irq_n), 32'h0);
            take("R2 winner vector", best);
            chk("R3 request dropped", 32'(irq_n), 32'h1);
            expect_level("R3 level after take", 1'b1, sweep_prio(best));
            done();
            @(negedge clk);
            src = '0;
            settle();
            expect_level("R8 level after done", 1'b0, 0);
        end

        // R4/R5: edge clears on take, level stays pending
        for (int i = 0; i < NS; i++) set_src(i, 0, 1'b0, 1'b0);
        set_src(2, 3, 1'b1, 1'b1);
        set_src(5, 1, 1'b0, 1'b1);
        @(negedge clk); src[5] = 1'b1;
        pulse(2);
        bus_read(A_PEND, d); chk("R4 R5 pending both", d, 32'h24);
        take("R4 edge take", 2);
        bus_read(A_PEND, d); chk("R4 edge cleared R5 level kept", d, 32'h20);
        chk("R7 lower level quiet", 32'(irq_n), 32'h1);
        done();
        chk("R9 reassert after pop", 32'(irq_n), 32'h0);
        take("R5 level take", 5);
        bus_read(A_PEND, d); chk("R5 level not cleared", d, 32'h20);
        @(negedge clk); src[5] = 1'b0;
        settle();
        bus_read(A_PEND, d); chk("R5 pending follows input", d, 32'h0);
        done();
        expect_level("R8 back to idle", 1'b0, 0);

        // R6: disabled source latches but does not request
        set_src(3, 6, 1'b1, 1'b0);
        pulse(3);
        chk("R6 disabled quiet", 32'(irq_n), 32'h1);
        bus_read(A_PEND, d); chk("R6 latched while disabled", d, 32'h08);
        set_src(3, 6, 1'b1, 1'b1);
        chk("R6 request on enable", 32'(irq_n), 32'h0);
        take("R6 take", 3);
        done();

        // R7/R8/R9: nesting with higher, equal and lower arrivals
        for (int i = 0; i < NS; i++) set_src(i, 0, 1'b0, 1'b0);
        set_src(0, 1, 1'b1, 1'b1);
        set_src(1, 6, 1'b1, 1'b1);
        set_src(4, 4, 1'b1, 1'b1);
        set_src(6, 6, 1'b1, 1'b1);
        pulse(0);
        take("R2 nest outer", 0);
        expect_level("R3 outer level", 1'b1, 1);
        pulse(1);
        chk("R7 preempt", 32'(irq_n), 32'h0);
        take("R2 nest inner", 1);
        expect_level("R8 push inner", 1'b1, 6);
        pulse(4);
        pulse(6);
        chk("R7 equal and lower quiet", 32'(irq_n), 32'h1);
        done();
        expect_level("R8 pop to outer", 1'b1, 1);
        chk("R9 reassert equal", 32'(irq_n), 32'h0);
        take("R2 equal source", 6);
        done();
        chk("R9 reassert lower", 32'(irq_n), 32'h0);
        take("R2 lower source", 4);
        expect_level("R3 lower level", 1'b1, 4);
        done();
        expect_level("R8 outer again", 1'b1, 1);
        chk("R7 nothing pending", 32'(irq_n), 32'h1);
        done();
        expect_level("R8 idle", 1'b0, 0);
        done();
        expect_level("R8 empty pop ignored", 1'b0, 0);

        // R11: take with nothing eligible
        bus_read(A_TAKE, d); chk("R11 idle take data", d, 32'h0);
        expect_level("R11 level unchanged", 1'b0, 0);

        // R10: full eight-deep nesting and unwind
        for (int i = 0; i < NS; i++) set_src(i, i, 1'b1, 1'b1);
        for (int k = 0; k < NS; k++) begin
            pulse(k);
            chk("R10 step request", 32'(irq_n), 32'h0);
            take("R10 step vector", k);
            expect_level("R10 step level", 1'b1, k);
        end
        for (int k = NS - 1; k >= 0; k--) begin
            done();
            expect_level("R10 unwind level", k > 0, k - 1);
        end
        chk("R10 final quiet", 32'(irq_n), 32'h1);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule